// File: doc/BRIEF.md
# Fault Response and Alert Controller

This block sits between a converter's fault detectors and its power stage. It receives an overcurrent flag and an undercurrent flag, both already sampled by a slow measurement path, plus an active-low external fault pin. It turns these into a single output-enable and an active-low alert line. Each fault class has its own response setting. A fault can be ignored, it can shut the output down and hold it off, or it can shut the output down and re-enable it after a programmable delay. The retry repeats for as long as the fault keeps coming back.

Every fault class sets a sticky status bit. The overcurrent and undercurrent bits always pull the alert line low. The external pin sets two status bits: a general "other fault" bit and a pin-specific bit. Its effect on the alert line can be masked, and the status bits are still set when the mask is on. A clear-faults strobe releases latched shutdowns and sticky status, but only for conditions that are no longer present. The retry delay is counted in ticks of an internal 1 ms enable, which is divided down from the clock by a parameter. The measured flags are not filtered, because their source already updates slowly. The external pin is assumed to be synchronous to the clock. It acts on the first cycle it is sampled low.

All pins are plain level control and status signals. There is no streaming data path, so no valid/ready handshake is needed and no back-pressure applies.

Top module: `fra_ctrl`

## Requirements
- R1: After reset, all status bits are 0, alert_n is 1, and out_en equals en_req.
- R2: A fault whose response is ignore (code 2'b00) leaves out_en unchanged.
- R3: With response latch (code 2'b01, and 2'b11 behaves the same), out_en goes low in the same cycle the fault flag is high. It stays low after the flag drops, until a clear_faults strobe arrives while the flag is low. out_en is high from the following cycle.
- R4: A clear_faults strobe has no effect on a latched shutdown, or on a status bit, while that fault's condition is still present.
- R5: With response retry (code 2'b10), out_en goes low in the same cycle as the fault. It returns high once retry_delay ticks of the 1 ms enable have elapsed, counted from the shutdown. A delay of 0 is treated as 1.
- R6: In retry mode, a fault still present when the delay expires shuts the output again and restarts the delay count. out_en therefore returns high only at the first expiry after the fault is gone.
- R7: A low level on ext_fault_n sets sts_other and sts_ext_pin in the next cycle. When ext_alert_mask is 0, it also drives alert_n low in that cycle.
- R8: When ext_alert_mask is 1, an external-pin fault leaves alert_n high, but it still sets both external status bits.
- R9: cfg_ext_retry = 0 makes the external pin ignored for out_en. cfg_ext_retry = 1 makes it shut down with timed retry, as in R5.
- R10: Status bits are sticky. They and alert_n are released only by clear_faults, and only when the condition is absent. The release is visible in the cycle after the strobe.
- R11: An overcurrent or undercurrent flag sets its status bit and drives alert_n low in the next cycle, whatever its response setting.
- R12: out_en is never high while en_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Requested output enable |
| oc_flag | input | 1 | Sampled overcurrent condition |
| uc_flag | input | 1 | Sampled undercurrent condition |
| ext_fault_n | input | 1 | External fault pin, active low |
| cfg_oc_resp | input | 2 | Overcurrent response code |
| cfg_uc_resp | input | 2 | Undercurrent response code |
| cfg_ext_retry | input | 1 | External pin: 0 ignore, 1 shutdown and retry |
| ext_alert_mask | input | 1 | Keep external-pin faults off the alert line |
| retry_delay | input | DLY_W | Retry delay in 1 ms ticks |
| clear_faults | input | 1 | Strobe releasing latched faults and status |
| out_en | output | 1 | Output enable to the power stage |
| alert_n | output | 1 | Alert line, active low |
| sts_oc | output | 1 | Sticky overcurrent status |
| sts_uc | output | 1 | Sticky undercurrent status |
| sts_other | output | 1 | Sticky general other-fault status |
| sts_ext_pin | output | 1 | Sticky external-pin status |

## Verification
The assertions assume that the configuration inputs (response codes, mask and retry enable) are held steady while a fault is in flight. They also assume that ext_fault_n is already synchronous to the clock. The stimulus changes configuration only inside a reset and drives every input on the falling clock edge. Fault flags are applied as clean levels of one or more whole cycles, which is how a slowly updating measurement source would present them.

// File: rtl/fra_pkg.sv
package fra_pkg;
  typedef enum logic [1:0] {
    RSP_IGNORE = 2'b00,
    RSP_LATCH  = 2'b01,
    RSP_RETRY  = 2'b10,
    RSP_LATCH2 = 2'b11
  } fra_resp_e;

  typedef enum logic [1:0] {
    CH_RUN     = 2'b00,
    CH_LATCHED = 2'b01,
    CH_WAIT    = 2'b10
  } fra_ch_state_e;

  localparam int unsigned FRA_NUM_CH = 3;
  localparam int unsigned FRA_CH_OC  = 0;
  localparam int unsigned FRA_CH_UC  = 1;
  localparam int unsigned FRA_CH_EXT = 2;
endpackage

// File: rtl/fra_tick_gen.sv
module fra_tick_gen #(
  parameter int unsigned TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/fra_fault_chan.sv
module fra_fault_chan
  import fra_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault,
  input  fra_resp_e        resp,
  input  logic [DLY_W-1:0] delay,
  input  logic             tick,
  input  logic             clear,
  output logic             off
);
  fra_ch_state_e    state_q;
  logic [DLY_W-1:0] cnt_q;
  logic             act;

  // a shutdown response is chosen this cycle
  assign act = fault && (resp != RSP_IGNORE);
  assign off = (state_q != CH_RUN) || act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        CH_RUN: begin
          if (act) begin
            if (resp == RSP_RETRY) begin
              state_q <= CH_WAIT;
              cnt_q   <= delay;
            end else begin
              state_q <= CH_LATCHED;
            end
          end
        end
        CH_LATCHED: begin
          if (clear && !fault) state_q <= CH_RUN;
        end
        CH_WAIT: begin
          if (tick) begin
            if (cnt_q <= DLY_W'(1)) state_q <= CH_RUN;
            else cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= CH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/fra_status.sv
module fra_status (
  input  logic clk,
  input  logic rst_n,
  input  logic oc,
  input  logic uc,
  input  logic ext_lo,
  input  logic mask,
  input  logic clear,
  output logic sts_oc,
  output logic sts_uc,
  output logic sts_other,
  output logic sts_ext_pin,
  output logic alert_n
);
  localparam int unsigned NB = 5;
  logic [NB-1:0] cond, bits_q;

  // 0 oc, 1 uc, 2 other, 3 ext pin, 4 ext alert source
  assign cond = {ext_lo && !mask, ext_lo, ext_lo, uc, oc};

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) bits_q[b] <= 1'b0;
      else if (cond[b]) bits_q[b] <= 1'b1;
      else if (clear) bits_q[b] <= 1'b0;
    end
  end

  assign sts_oc      = bits_q[0];
  assign sts_uc      = bits_q[1];
  assign sts_other   = bits_q[2];
  assign sts_ext_pin = bits_q[3];
  assign alert_n     = !(bits_q[0] || bits_q[1] || bits_q[4]);
endmodule

// File: rtl/fra_ctrl.sv
module fra_ctrl
  import fra_pkg::*;
#(
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned DLY_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             oc_flag,
  input  logic             uc_flag,
  input  logic             ext_fault_n,
  input  logic [1:0]       cfg_oc_resp,
  input  logic [1:0]       cfg_uc_resp,
  input  logic             cfg_ext_retry,
  input  logic             ext_alert_mask,
  input  logic [DLY_W-1:0] retry_delay,
  input  logic             clear_faults,
  output logic             out_en,
  output logic             alert_n,
  output logic             sts_oc,
  output logic             sts_uc,
  output logic             sts_other,
  output logic             sts_ext_pin
);
  logic                  tick;
  logic                  ext_lo;
  logic [FRA_NUM_CH-1:0] ch_fault, ch_off;
  fra_resp_e             ch_resp [FRA_NUM_CH];

  assign ext_lo = !ext_fault_n;

  assign ch_fault[FRA_CH_OC]  = oc_flag;
  assign ch_fault[FRA_CH_UC]  = uc_flag;
  assign ch_fault[FRA_CH_EXT] = ext_lo;
  assign ch_resp[FRA_CH_OC]   = fra_resp_e'(cfg_oc_resp);
  assign ch_resp[FRA_CH_UC]   = fra_resp_e'(cfg_uc_resp);
  assign ch_resp[FRA_CH_EXT]  = cfg_ext_retry ? RSP_RETRY : RSP_IGNORE;

  fra_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar c = 0; c < FRA_NUM_CH; c++) begin : g_ch
    fra_fault_chan #(.DLY_W(DLY_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .fault(ch_fault[c]), .resp(ch_resp[c]),
      .delay(retry_delay), .tick(tick), .clear(clear_faults), .off(ch_off[c])
    );
  end

  fra_status u_sts (
    .clk(clk), .rst_n(rst_n), .oc(oc_flag), .uc(uc_flag), .ext_lo(ext_lo),
    .mask(ext_alert_mask), .clear(clear_faults), .sts_oc(sts_oc),
    .sts_uc(sts_uc), .sts_other(sts_other), .sts_ext_pin(sts_ext_pin),
    .alert_n(alert_n)
  );

  assign out_en = en_req && !(|ch_off);
endmodule

// File: rtl/fra_ctrl_chk.sv
module fra_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_req,
  input logic       oc_flag,
  input logic       uc_flag,
  input logic       ext_fault_n,
  input logic [1:0] cfg_oc_resp,
  input logic       cfg_ext_retry,
  input logic       ext_alert_mask,
  input logic       clear_faults,
  input logic       out_en,
  input logic       alert_n,
  input logic       sts_oc,
  input logic       sts_uc,
  input logic       sts_other,
  input logic       sts_ext_pin
);
  assert_latch_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && cfg_oc_resp[0]) |-> !out_en);
  assert_ext_retry_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_fault_n && cfg_ext_retry) |-> !out_en);
  assert_oc_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> (sts_oc && !alert_n));
  assert_uc_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    uc_flag |=> (sts_uc && !alert_n));
  assert_ext_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_fault_n |=> (sts_other && sts_ext_pin));
  assert_ext_alert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_fault_n && !ext_alert_mask) |=> !alert_n);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_oc && !clear_faults) |=> sts_oc);
  assert_no_clear_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_uc && uc_flag) |=> sts_uc);
  assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |-> !out_en);
endmodule

bind fra_ctrl fra_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_req(en_req), .oc_flag(oc_flag),
  .uc_flag(uc_flag), .ext_fault_n(ext_fault_n), .cfg_oc_resp(cfg_oc_resp),
  .cfg_ext_retry(cfg_ext_retry), .ext_alert_mask(ext_alert_mask),
  .clear_faults(clear_faults), .out_en(out_en), .alert_n(alert_n),
  .sts_oc(sts_oc), .sts_uc(sts_uc), .sts_other(sts_other),
  .sts_ext_pin(sts_ext_pin)
);

// File: tb/tb_fra_ctrl.sv
module tb_fra_ctrl;
  localparam int unsigned DIV = 8;
  localparam int unsigned DW  = 16;
  localparam int unsigned NV  = 10;
  // {oc, uc, ext_lo, oc_resp[1:0], uc_resp[1:0], ext_retry, mask, exp_en, exp_alert_n}
  localparam logic [10:0] VEC [NV] = '{
    11'b100_00_00_0_0_1_0,  // R2 R11 oc ignored
    11'b100_01_00_0_0_0_0,  // R3 oc latch
    11'b010_00_10_0_0_0_0,  // R5 uc retry
    11'b010_00_00_0_0_1_0,  // R2 uc ignored
    11'b001_00_00_0_0_1_0,  // R9 R7 ext ignored
    11'b001_00_00_1_0_0_0,  // R9 ext retry
    11'b001_00_00_1_1_0_1,  // R8 masked
    11'b001_00_00_0_1_1_1,  // R8 masked, ignored
    11'b000_01_01_1_0_1_1,  // R1 no fault
    11'b110_00_01_0_0_0_0   // R2 R3 mixed
  };

  logic clk = 0, rst_n = 0, en_req = 1, oc_flag = 0, uc_flag = 0, ext_fault_n = 1;
  logic [1:0] cfg_oc_resp = 0, cfg_uc_resp = 0;
  logic cfg_ext_retry = 0, ext_alert_mask = 0, clear_faults = 0;
  logic [DW-1:0] retry_delay = 0;
  logic out_en, alert_n, sts_oc, sts_uc, sts_other, sts_ext_pin;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fra_ctrl #(.TICK_DIV(DIV), .DLY_W(DW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; oc_flag = 0; uc_flag = 0; ext_fault_n = 1; clear_faults = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_en(input int lim, output int n);
    n = 0;
    while (!out_en && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    do_reset();
    #1;
    chk("R1 out_en", out_en, 1);
    chk("R1 alert_n", alert_n, 1);
    chk("R1 status", {sts_oc, sts_uc, sts_other, sts_ext_pin}, 0);
    en_req = 0; #1;
    chk("R12 gate", out_en, 0);
    en_req = 1;

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      @(negedge clk);
      rst_n = 0;
      {cfg_oc_resp, cfg_uc_resp, cfg_ext_retry, ext_alert_mask} = v[7:2];
      retry_delay = 4;
      do_reset();
      @(negedge clk);
      oc_flag = v[10]; uc_flag = v[9]; ext_fault_n = !v[8];
      #1;
      chk($sformatf("R2/R3/R9 vec%0d out_en", i), out_en, v[1]);
      @(negedge clk);
      chk($sformatf("R7/R8/R11 vec%0d alert_n", i), alert_n, v[0]);
      chk($sformatf("R11 vec%0d sts", i), {sts_oc, sts_uc}, {v[10], v[9]});
      chk($sformatf("R7 vec%0d ext sts", i), {sts_other, sts_ext_pin}, {v[8], v[8]});
    end

    // latch hold and conditional clear
    cfg_oc_resp = 2'b01; cfg_uc_resp = 0; cfg_ext_retry = 0; ext_alert_mask = 0;
    do_reset();
    @(negedge clk); oc_flag = 1; #1;
    chk("R3 same cycle", out_en, 0);
    @(negedge clk); oc_flag = 0;
    repeat (40) @(negedge clk);
    chk("R3 held", out_en, 0);
    oc_flag = 1; clear_faults = 1;
    @(negedge clk); clear_faults = 0;
    chk("R4 latch kept", out_en, 0);
    chk("R4 sts kept", sts_oc, 1);
    oc_flag = 0; clear_faults = 1;
    @(negedge clk); clear_faults = 0;
    chk("R3 released", out_en, 1);
    chk("R10 sts cleared", sts_oc, 0);
    chk("R10 alert released", alert_n, 1);

    // retry timing
    cfg_oc_resp = 2'b10; retry_delay = 3;
    do_reset();
    @(negedge clk); oc_flag = 1; #1;
    chk("R5 shut", out_en, 0);
    @(negedge clk); oc_flag = 0;
    wait_en(200, n);
    chk("R5 delay low", int'(n >= 2 * DIV - 1), 1);
    chk("R5 delay high", int'(n <= 3 * DIV + 2), 1);
    chk("R10 sts stays", sts_oc, 1);

    retry_delay = 0;
    do_reset();
    @(negedge clk); oc_flag = 1;
    @(negedge clk); oc_flag = 0;
    wait_en(200, n);
    chk("R5 zero delay", int'(n >= 1 && n <= DIV + 2), 1);

    // repeated retry while fault persists
    retry_delay = 2;
    do_reset();
    @(negedge clk); oc_flag = 1;
    repeat (40) @(negedge clk);
    chk("R6 still off", out_en, 0);
    oc_flag = 0;
    wait_en(200, n);
    chk("R6 re-enable at later expiry", int'(n >= 1 && n <= 2 * DIV + 4), 1);

    // external retry, masked alert
    cfg_oc_resp = 0; cfg_ext_retry = 1; ext_alert_mask = 1; retry_delay = 2;
    do_reset();
    @(negedge clk); ext_fault_n = 0; #1;
    chk("R9 ext shut", out_en, 0);
    @(negedge clk); ext_fault_n = 1;
    chk("R8 alert masked", alert_n, 1);
    wait_en(200, n);
    chk("R9 ext retry", int'(n >= DIV - 1 && n <= 2 * DIV + 2), 1);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule